// File: doc/BRIEF.md
# Console Buffer Transfer Engine

This block moves bytes between system memory and a console's byte streams for a register controller that starts it. The controller hands over a direction, a 64-bit start address and a 32-bit byte count with a one-cycle start strobe. For an output transfer the engine fetches bytes from memory one at a time over a byte-wide read port. It collects them in a local chunk store and then plays the chunk out on a valid/ready transmit stream. The next chunk is fetched only after the current one has been fully sent.

For an input transfer the engine takes bytes from the head of a receive FIFO and stores them at rising addresses through a request/accept write port. It stops as soon as the count is used up or the FIFO has nothing left, whichever comes first. At the end it reports how much of the count went unused. If interrupts are on and the FIFO was drained, it also asks for the receive interrupt to be dropped.

Top module: `con_xfer_engine`

## Requirements
- R1: A start strobe seen while idle is taken; `busy` is high from the next cycle through the cycle of the one-cycle `done` pulse and low after it; a start strobe while busy is ignored.
- R2: An output transfer (`cmdOp`=0) sends exactly `cmdLen` bytes on the transmit stream; byte i equals the memory byte at `cmdPtr`+i, and `txData` holds while `txValid` waits for `txReady`.
- R3: Output memory reads happen in runs of min(CHUNK, bytes still to send); no read is issued while a fetched byte is still waiting to be sent.
- R4: At most one memory read is outstanding: after a one-cycle `memRdReq` pulse the next request comes only after `memRdValid` returned the byte.
- R5: An input transfer (`cmdOp`=1) writes the FIFO head byte to `cmdPtr`+i for the i-th byte, pops the FIFO once per accepted write, and holds request, address and data stable until accepted.
- R6: An input transfer writes exactly min(`cmdLen`, bytes in the FIFO) bytes, stopping on an exhausted count or an empty FIFO.
- R7: A zero count causes no memory read, memory write, stream byte or FIFO pop, and `done` pulses the cycle after the start.
- R8: `irqClear` pulses only together with `done`, and only after an input transfer that ended with interrupts enabled (`intEnabled`=1) and the FIFO empty.
- R9: After an input transfer, `leftover` reads `cmdLen` minus the bytes written, from the cycle after `done`; an output transfer leaves it unchanged.
- R10: After reset, `busy`, `done`, `memRdReq`, `memWrReq`, `txValid` and `leftover` are all zero.
- R11: Addresses are full 64-bit values and carry across the 32-bit boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Start strobe, one cycle |
| cmdOp | input | 1 | 0 = memory to transmit stream, 1 = receive FIFO to memory |
| cmdPtr | input | 64 | Start byte address |
| cmdLen | input | 32 | Byte count |
| intEnabled | input | 1 | Receive interrupt currently enabled |
| memRdReq | output | 1 | One-cycle memory read request |
| memRdAddr | output | 64 | Read address |
| memRdValid | input | 1 | Read data returned |
| memRdData | input | 8 | Read data byte |
| txValid | output | 1 | Transmit byte available |
| txData | output | 8 | Transmit byte |
| txReady | input | 1 | Transmit sink takes the byte |
| rxEmpty | input | 1 | Receive FIFO empty |
| rxData | input | 8 | Receive FIFO head byte |
| rxPop | output | 1 | Remove FIFO head |
| memWrReq | output | 1 | Memory write request |
| memWrAddr | output | 64 | Write address |
| memWrData | output | 8 | Write data byte |
| memWrAccept | input | 1 | Write taken |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| irqClear | output | 1 | Request to drop the receive interrupt |
| leftover | output | 32 | Unused count of the last input transfer |

## Verification
The hardest case to reach is a chunk boundary that meets a stalled transmit sink and a slow memory at the same time. The engine must then hold off the next read until the last byte of the chunk has left. The bench uses a small chunk size and counts near and across its multiples. It randomizes read latency, `txReady` and `memWrAccept` on every cycle. For each chunk it compares the number of reads before the first byte leaves with the bytes still owed. The input side is driven with FIFO fill levels below, equal to and above the count, so that both stop conditions and both interrupt outcomes occur.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL_REQ,
    ST_FILL_WAIT,
    ST_DRAIN,
    ST_PUSH,
    ST_FINISH
  } xferState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;      // capture pointer and count, clear chunk
    logic ptrInc;    // advance address by one byte
    logic remDec;    // one byte consumed from the count
    logic fillWr;    // store returned read byte in chunk store
    logic drainAdv;  // one chunk byte sent
    logic chunkClr;  // chunk fully sent, restart fill
    logic saveLeft;  // latch unused count
  } dpStrobe_t;

  localparam logic OP_OUT = 1'b0;
  localparam logic OP_IN  = 1'b1;

endpackage

// File: rtl/xfer_dpath.sv
module xfer_dpath
  import xfer_pkg::*;
#(
  parameter int PTR_W = 64,
  parameter int LEN_W = 32,
  parameter int CHUNK = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        stb,
  input  logic [PTR_W-1:0] cmdPtr,
  input  logic [LEN_W-1:0] cmdLen,
  input  logic [7:0]       rdData,
  output logic [PTR_W-1:0] curPtr,
  output logic             remZero,
  output logic             remOne,
  output logic             fillLast,
  output logic             drainLast,
  output logic [7:0]       bufByte,
  output logic [LEN_W-1:0] leftover
);

  localparam int IDX_W = (CHUNK > 1) ? $clog2(CHUNK) : 1;
  localparam int CNT_W = $clog2(CHUNK + 1);

  logic [LEN_W-1:0] remLen;
  logic [CNT_W-1:0] fillCnt;
  logic [CNT_W-1:0] drainIdx;
  logic [7:0]       chunkMem [CHUNK];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curPtr <= '0;
      remLen <= '0;
    end else if (stb.load) begin
      curPtr <= cmdPtr;
      remLen <= cmdLen;
    end else begin
      if (stb.ptrInc) curPtr <= curPtr + PTR_W'(1);
      if (stb.remDec) remLen <= remLen - LEN_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fillCnt  <= '0;
      drainIdx <= '0;
    end else if (stb.load || stb.chunkClr) begin
      fillCnt  <= '0;
      drainIdx <= '0;
    end else begin
      if (stb.fillWr)   fillCnt  <= fillCnt + CNT_W'(1);
      if (stb.drainAdv) drainIdx <= drainIdx + CNT_W'(1);
    end
  end

  // chunk store, one write port at the fill index
  generate
    for (genvar gi = 0; gi < CHUNK; gi++) begin : g_slot
      always_ff @(posedge clk) begin
        if (stb.fillWr && (fillCnt[IDX_W-1:0] == IDX_W'(gi)))
          chunkMem[gi] <= rdData;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN)             leftover <= '0;
    else if (stb.saveLeft) leftover <= remLen;
  end

  assign remZero   = (remLen == '0);
  assign remOne    = (remLen == LEN_W'(1));
  assign fillLast  = (fillCnt == CNT_W'(CHUNK - 1));
  assign drainLast = ((drainIdx + CNT_W'(1)) == fillCnt);
  assign bufByte   = chunkMem[drainIdx[IDX_W-1:0]];

  // R3: the chunk store never takes more than CHUNK bytes
  p_fill_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.fillWr |-> (fillCnt < CNT_W'(CHUNK)));

  // R6: the count is never consumed past zero
  p_rem_no_underflow_r6: assert property (@(posedge clk) disable iff (!rstN)
    stb.remDec |-> (remLen != '0));

  // R3: a byte is sent only from the filled part of the chunk
  p_drain_in_fill_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.drainAdv |-> (drainIdx < fillCnt));

endmodule

// File: rtl/xfer_ctrl.sv
module xfer_ctrl
  import xfer_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cmdValid,
  input  logic      cmdOp,
  input  logic      cmdLenZero,
  input  logic      intEnabled,
  input  logic      remZero,
  input  logic      remOne,
  input  logic      fillLast,
  input  logic      drainLast,
  input  logic      memRdValid,
  input  logic      txReady,
  input  logic      rxEmpty,
  input  logic      memWrAccept,
  output dpStrobe_t stb,
  output logic      memRdReq,
  output logic      txValid,
  output logic      memWrReq,
  output logic      rxPop,
  output logic      busy,
  output logic      done,
  output logic      irqClear
);

  xferState_e state, stateNext;
  logic       isRead;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      isRead <= 1'b0;
    end else begin
      state <= stateNext;
      if (stb.load) isRead <= (cmdOp == OP_IN);
    end
  end

  always_comb begin
    stateNext = state;
    stb       = '0;
    memRdReq  = 1'b0;
    txValid   = 1'b0;
    memWrReq  = 1'b0;
    rxPop     = 1'b0;
    done      = 1'b0;
    irqClear  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (cmdValid) begin
          stb.load = 1'b1;
          if (cmdLenZero)          stateNext = ST_FINISH;
          else if (cmdOp == OP_IN) stateNext = ST_PUSH;
          else                     stateNext = ST_FILL_REQ;
        end
      end
      ST_FILL_REQ: begin
        memRdReq  = 1'b1;
        stateNext = ST_FILL_WAIT;
      end
      ST_FILL_WAIT: begin
        if (memRdValid) begin
          stb.fillWr = 1'b1;
          stb.ptrInc = 1'b1;
          stb.remDec = 1'b1;
          stateNext  = (remOne || fillLast) ? ST_DRAIN : ST_FILL_REQ;
        end
      end
      ST_DRAIN: begin
        txValid = 1'b1;
        if (txReady) begin
          stb.drainAdv = 1'b1;
          if (drainLast) begin
            if (remZero) begin
              stateNext = ST_FINISH;
            end else begin
              stb.chunkClr = 1'b1;
              stateNext    = ST_FILL_REQ;
            end
          end
        end
      end
      ST_PUSH: begin
        if (remZero || rxEmpty) begin
          stateNext = ST_FINISH;
        end else begin
          memWrReq = 1'b1;
          if (memWrAccept) begin
            rxPop      = 1'b1;
            stb.ptrInc = 1'b1;
            stb.remDec = 1'b1;
          end
        end
      end
      ST_FINISH: begin
        done         = 1'b1;
        stb.saveLeft = isRead;
        irqClear     = isRead && intEnabled && rxEmpty;
        stateNext    = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);

  // R1: busy holds until the done pulse
  p_busy_until_done_r1: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);

  // R1: idle right after done
  p_idle_after_done_r1: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy && !done);

  // R4: a read request is a single-cycle pulse
  p_one_outstanding_r4: assert property (@(posedge clk) disable iff (!rstN)
    memRdReq |=> !memRdReq);

  // R3: no fetch while a chunk byte waits
  p_no_read_while_tx_r3: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> !memRdReq);

  // R8: interrupt clear only with done
  p_irq_with_done_r8: assert property (@(posedge clk) disable iff (!rstN)
    irqClear |-> done);

  // R5: pops only with an accepted write
  p_pop_with_write_r5: assert property (@(posedge clk) disable iff (!rstN)
    rxPop |-> (memWrReq && memWrAccept && !rxEmpty));

endmodule

// File: rtl/con_xfer_engine.sv
module con_xfer_engine
  import xfer_pkg::*;
#(
  parameter int PTR_W = 64,
  parameter int LEN_W = 32,
  parameter int CHUNK = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic             cmdOp,
  input  logic [PTR_W-1:0] cmdPtr,
  input  logic [LEN_W-1:0] cmdLen,
  input  logic             intEnabled,
  output logic             memRdReq,
  output logic [PTR_W-1:0] memRdAddr,
  input  logic             memRdValid,
  input  logic [7:0]       memRdData,
  output logic             txValid,
  output logic [7:0]       txData,
  input  logic             txReady,
  input  logic             rxEmpty,
  input  logic [7:0]       rxData,
  output logic             rxPop,
  output logic             memWrReq,
  output logic [PTR_W-1:0] memWrAddr,
  output logic [7:0]       memWrData,
  input  logic             memWrAccept,
  output logic             busy,
  output logic             done,
  output logic             irqClear,
  output logic [LEN_W-1:0] leftover
);

  dpStrobe_t        stb;
  logic             remZero, remOne, fillLast, drainLast;
  logic [PTR_W-1:0] curPtr;
  logic             cmdLenZero;

  assign cmdLenZero = (cmdLen == '0);

  xfer_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cmdValid   (cmdValid),
    .cmdOp      (cmdOp),
    .cmdLenZero (cmdLenZero),
    .intEnabled (intEnabled),
    .remZero    (remZero),
    .remOne     (remOne),
    .fillLast   (fillLast),
    .drainLast  (drainLast),
    .memRdValid (memRdValid),
    .txReady    (txReady),
    .rxEmpty    (rxEmpty),
    .memWrAccept(memWrAccept),
    .stb        (stb),
    .memRdReq   (memRdReq),
    .txValid    (txValid),
    .memWrReq   (memWrReq),
    .rxPop      (rxPop),
    .busy       (busy),
    .done       (done),
    .irqClear   (irqClear)
  );

  xfer_dpath #(
    .PTR_W(PTR_W),
    .LEN_W(LEN_W),
    .CHUNK(CHUNK)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .cmdPtr   (cmdPtr),
    .cmdLen   (cmdLen),
    .rdData   (memRdData),
    .curPtr   (curPtr),
    .remZero  (remZero),
    .remOne   (remOne),
    .fillLast (fillLast),
    .drainLast(drainLast),
    .bufByte  (txData),
    .leftover (leftover)
  );

  assign memRdAddr = curPtr;
  assign memWrAddr = curPtr;
  assign memWrData = rxData;

  // R7: a zero count finishes on the next cycle
  p_zero_len_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !busy && cmdLenZero) |=> done);

  // R5: write request holds its address and data until accepted
  p_wr_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (memWrReq && !memWrAccept) |=> memWrReq && $stable(memWrAddr) && $stable(memWrData));

  // R2: transmit byte holds while the sink stalls
  p_tx_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> txValid && $stable(txData));

endmodule

// File: tb/sim_con_xfer_engine.sv
module sim_con_xfer_engine;

  localparam int CLK_PERIOD = 10;
  localparam int CHUNK      = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic        cmdOp = 1'b0;
  logic [63:0] cmdPtr = '0;
  logic [31:0] cmdLen = '0;
  logic        intEnabled = 1'b0;
  logic        memRdReq;
  logic [63:0] memRdAddr;
  logic        memRdValid = 1'b0;
  logic [7:0]  memRdData = '0;
  logic        txValid;
  logic [7:0]  txData;
  logic        txReady = 1'b0;
  logic        rxEmpty = 1'b1;
  logic [7:0]  rxData = '0;
  logic        rxPop;
  logic        memWrReq;
  logic [63:0] memWrAddr;
  logic [7:0]  memWrData;
  logic        memWrAccept = 1'b0;
  logic        busy, done, irqClear;
  logic [31:0] leftover;

  con_xfer_engine #(.CHUNK(CHUNK)) u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int nChk = 0;
  int nFail = 0;

  logic [7:0]  rxQ[$];
  logic [7:0]  gotTx[$];
  logic [63:0] gotRd[$];
  logic [63:0] gotWrA[$];
  logic [7:0]  gotWrD[$];
  logic        popPending = 1'b0;
  int          rdLat = 0;
  logic [63:0] rdPend = '0;
  int          readRun = 0;
  bit          inDrain = 1'b0;
  logic [31:0] expLeft = '0;
  logic [31:0] curLen = '0;

  function automatic logic [7:0] memByte(input logic [63:0] a);
    logic [7:0] m;
    m = a[23:16] + a[23:16] + a[23:16];
    return a[7:0] ^ a[15:8] ^ m ^ a[39:32] ^ a[63:56] ^ 8'hA5;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // environment: memory, transmit sink, receive FIFO
  always @(negedge clk) begin
    if (popPending) begin
      void'(rxQ.pop_front());
      popPending = 1'b0;
    end
    rxEmpty = (rxQ.size() == 0);
    rxData  = rxEmpty ? 8'h00 : rxQ[0];
    memRdValid = 1'b0;
    if (rdLat > 0) begin
      rdLat--;
      if (rdLat == 0) begin
        memRdValid = 1'b1;
        memRdData  = memByte(rdPend);
      end
    end
    #1;
    if (rstN && memRdReq) begin
      if (rdLat != 0 || memRdValid)
        chk(1'b0, "R4 second read outstanding", 64'(rdLat), 64'd0);
      if (inDrain) begin
        inDrain = 1'b0;
        readRun = 0;
      end
      readRun++;
      gotRd.push_back(memRdAddr);
      rdPend = memRdAddr;
      rdLat  = 1 + int'($urandom % 3);
    end
    txReady = ($urandom % 4) != 0;
    if (rstN && txValid && txReady) begin
      if (!inDrain) begin
        int owed;
        owed = int'(curLen) - gotTx.size();
        if (owed > CHUNK) owed = CHUNK;
        chk(readRun == owed, "R3 reads per chunk", 64'(readRun), 64'(owed));
        inDrain = 1'b1;
      end
      gotTx.push_back(txData);
    end
    memWrAccept = ($urandom % 5) < 3;
    if (rstN && memWrReq && memWrAccept) begin
      gotWrA.push_back(memWrAddr);
      gotWrD.push_back(memWrData);
      popPending = 1'b1;
    end
  end

  task automatic runCmd(input logic op, input logic [63:0] ptr, input logic [31:0] len,
                        input logic ie, input int nRx);
    logic [7:0] pre[$];
    int n, waitCnt;
    @(negedge clk); #2;
    gotTx.delete(); gotRd.delete(); gotWrA.delete(); gotWrD.delete();
    rxQ.delete();
    readRun = 0; inDrain = 1'b0; curLen = len;
    for (int i = 0; i < nRx; i++) begin
      logic [7:0] b;
      b = 8'($urandom);
      rxQ.push_back(b);
      pre.push_back(b);
    end
    cmdValid = 1'b1; cmdOp = op; cmdPtr = ptr; cmdLen = len; intEnabled = ie;
    @(negedge clk); #2;
    cmdValid = 1'b0;
    chk(busy == 1'b1, "R1 busy after start", 64'(busy), 64'd1);
    if (!done) begin
      cmdValid = 1'b1; cmdOp = ~op; cmdLen = 32'd5; cmdPtr = 64'h1234;
      @(negedge clk); #2;
      cmdValid = 1'b0;
    end
    waitCnt = 0;
    while (!done && waitCnt < 5000) begin
      chk(busy == 1'b1, "R1 busy held", 64'(busy), 64'd1);
      @(negedge clk); #2;
      waitCnt++;
    end
    n = (op == 1'b1) ? ((int'(len) < nRx) ? int'(len) : nRx) : 0;
    chk(irqClear == (op && ie && (nRx - n == 0)), "R8 irqClear", 64'(irqClear),
        64'(op && ie && (nRx - n == 0)));
    @(negedge clk); #2;
    chk(busy == 1'b0 && done == 1'b0, "R1 idle after done", 64'({busy, done}), 64'd0);
    if (op) expLeft = len - 32'(n);
    chk(leftover == expLeft, "R9 leftover", 64'(leftover), 64'(expLeft));
    if (op == 1'b0) begin
      chk(gotTx.size() == int'(len), "R2 byte count", 64'(gotTx.size()), 64'(len));
      chk(gotRd.size() == int'(len), "R2 read count", 64'(gotRd.size()), 64'(len));
      for (int i = 0; i < gotTx.size() && i < int'(len); i++) begin
        chk(gotTx[i] == memByte(ptr + 64'(i)), "R2 tx byte", 64'(gotTx[i]), 64'(memByte(ptr + 64'(i))));
        chk(gotRd[i] == ptr + 64'(i), "R11 read address", gotRd[i], ptr + 64'(i));
      end
      chk(gotWrA.size() == 0, "R2 no write on output", 64'(gotWrA.size()), 64'd0);
    end else begin
      chk(gotWrA.size() == n, "R6 write count", 64'(gotWrA.size()), 64'(n));
      chk(rxQ.size() == nRx - n, "R6 fifo level", 64'(rxQ.size()), 64'(nRx - n));
      for (int i = 0; i < gotWrA.size() && i < n; i++) begin
        chk(gotWrA[i] == ptr + 64'(i), "R5 write address", gotWrA[i], ptr + 64'(i));
        chk(gotWrD[i] == pre[i], "R5 write data", 64'(gotWrD[i]), 64'(pre[i]));
      end
      chk(gotRd.size() == 0 && gotTx.size() == 0, "R5 no read on input",
          64'(gotRd.size() + gotTx.size()), 64'd0);
    end
    if (len == 0)
      chk(gotRd.size() + gotTx.size() + gotWrA.size() == 0 && rxQ.size() == nRx,
          "R7 zero count idle", 64'(gotRd.size() + gotTx.size() + gotWrA.size()), 64'd0);
  endtask

  initial begin
    int cyc;
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        nFail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd7321));
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    #2;
    chk({busy, done, memRdReq, memWrReq, txValid} == 5'b0, "R10 reset outputs",
        64'({busy, done, memRdReq, memWrReq, txValid}), 64'd0);
    chk(leftover == 32'd0, "R10 reset leftover", 64'(leftover), 64'd0);
    rstN = 1'b1;
    // directed corners
    runCmd(1'b0, 64'h100, 32'd0, 1'b1, 3);                       // R7 output
    runCmd(1'b1, 64'h200, 32'd0, 1'b1, 0);                       // R7 input, empty FIFO
    runCmd(1'b0, 64'h1000, 32'(CHUNK), 1'b0, 0);                 // R3 exact chunk
    runCmd(1'b0, 64'h2000, 32'(CHUNK + 1), 1'b0, 0);             // R3 one over
    runCmd(1'b0, 64'h3000, 32'(3 * CHUNK - 1), 1'b0, 0);         // R3 several chunks
    runCmd(1'b0, 64'h0000_0000_FFFF_FFFC, 32'd10, 1'b0, 0);      // R11 carry
    runCmd(1'b1, 64'h0000_0000_FFFF_FFFE, 32'd6, 1'b1, 6);       // R11, R8 drained
    runCmd(1'b1, 64'h4000, 32'd20, 1'b1, 5);                     // R6 FIFO runs dry
    runCmd(1'b1, 64'h5000, 32'd4, 1'b1, 9);                      // R6 count runs out, R8 no clear
    runCmd(1'b1, 64'h6000, 32'd7, 1'b0, 3);                      // R8 interrupts off
    runCmd(1'b0, 64'h7000, 32'd1, 1'b0, 0);                      // R9 unchanged by output
    // random mix
    for (int k = 0; k < 40; k++) begin
      logic [31:0] l;
      l = ($urandom % 6 == 0) ? 32'd0 : 32'($urandom % 30);
      runCmd(1'($urandom % 2), {32'($urandom), 32'($urandom)}, l, 1'($urandom % 2),
             int'($urandom % 25));
    end
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

endmodule